// File: doc/BRIEF.md
# Function Unit Result Forwarding Controller

This block looks after the single result held by one function unit in a scoreboard-driven out-of-order core. A result enters through a valid/ready port and is held until the block decides it can be let go. While held it may be broadcast once on a forwarding bus: every operand latch in the core whose own read is pending can capture it in that same cycle. The decision to forward uses only a reduction of the global read-pending vector, so no producer-to-consumer match matrix is needed.

Forwarding does not end the result's life. The block keeps the value and a flag saying that the register file still has to be written. A grant from the write-port arbiter clears that flag. The held value is dropped once no shadow covers the unit and no read hazard points at it, provided it has been either forwarded or written. Shadows cover branch speculation, pending exceptions and write-after-write cancellation. A squash input cancels the result at once: nothing further is forwarded or written for it.

Back-pressure: `in_ready` is high only while nothing is held. A transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_valid` and `in_data` are ignored and the producer must hold its item. The forwarding and write sides have no back-pressure: `fwd_en` is a one-cycle strobe, and `wr_need` stays high until a grant arrives.

Top module: `fu_fwd_ctrl`

## Requirements
- R1: After reset, `fwd_en`, `wr_need` and `drop` are low, `in_ready` is high and `res_data` is zero.
- R2: A transfer captures `in_data`. From the next cycle `in_ready` is low, `wr_need` is high and `res_data` shows the captured value. While a result is held, `in_valid` and `in_data` leave `res_data` unchanged.
- R3: `fwd_en` is high in a cycle exactly when a result is held, it has not yet been forwarded, `squash` is low and at least one bit of `rd_pend` is set. The set bit may be any bit.
- R4: `fwd_en` is high for at most one cycle per held result.
- R5: A forward that coincides with no drop leaves the result held. `res_data` is unchanged, and `wr_need` is unchanged unless a grant arrives in that cycle.
- R6: `wr_gnt` while `wr_need` is high clears `wr_need` from the next cycle. `wr_gnt` while nothing is held has no effect on the next result.
- R7: Without a squash, `drop` is high exactly when a result is held, every bit of `shadow` is zero, every bit of `rd_hazard` is zero, and the result has already been forwarded or `wr_need` is low. Any single shadow bit or hazard bit blocks the drop.
- R8: `squash` while a result is held raises `drop` in the same cycle and suppresses `fwd_en`, even when `rd_pend` is set.
- R9: In the cycle after `drop`, `in_ready` is high and `wr_need` is low.
- R10: A held result that has been neither forwarded nor granted a write is never dropped without a squash, even when there is no shadow and no hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Result offered by the function unit |
| in_ready | output | 1 | High when no result is held |
| in_data | input | DW | Result value |
| rd_pend | input | NFU | Global read-pending vector, one bit per unit |
| shadow | input | NSH | Active shadows on this unit (branch, exception, write-after-write) |
| rd_hazard | input | NFU | Readers still depending on this unit's result |
| squash | input | 1 | Cancel the held result |
| wr_gnt | input | 1 | Register-file write port granted to this unit |
| fwd_en | output | 1 | One-cycle strobe: broadcast `res_data` on the forwarding bus |
| wr_need | output | 1 | Held result still has to be written to the register file |
| drop | output | 1 | Held result is released in this cycle |
| res_data | output | DW | Held result value |

## Verification
Two pairs of events can fall in the same cycle. A squash can arrive while reads are pending, so a forward is possible in that cycle. The bench drives both together and expects `drop` high and `fwd_en` low. The second pair is a first forward in a cycle where the drop conditions already hold. The bench provokes it by granting the write earlier and then raising `rd_pend` with shadows and hazards clear. It expects `fwd_en` and `drop` together, followed by an idle unit in the next cycle.

// File: rtl/fwdc_pkg.sv
package fwdc_pkg;

  typedef struct packed {
    logic hold;
    logic need;
    logic sent;
  } life_t;

  localparam life_t LIFE_IDLE = '{hold: 1'b0, need: 1'b0, sent: 1'b0};

endpackage

// File: rtl/fwdc_any.sv
module fwdc_any #(
  parameter int W = 4
) (
  input  logic [W-1:0] vec,
  output logic         any
);
  logic [W:0] acc;

  assign acc[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_or
      assign acc[i+1] = acc[i] | vec[i];
    end
  endgenerate

  assign any = acc[W];
endmodule

// File: rtl/fwdc_hold.sv
module fwdc_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/fwdc_life.sv
module fwdc_life
  import fwdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic pend_any,
  input  logic shadow_any,
  input  logic hazard_any,
  input  logic squash,
  input  logic wr_gnt,
  output logic in_ready,
  output logic load,
  output logic fwd_en,
  output logic wr_need,
  output logic drop
);
  life_t st, st_n;
  logic  quiet;

  assign in_ready = !st.hold;
  assign load     = in_valid && !st.hold;
  assign quiet    = !shadow_any && !hazard_any;
  assign fwd_en   = st.hold && !st.sent && pend_any && !squash;
  assign drop     = st.hold && (squash || (quiet && (st.sent || !st.need)));
  assign wr_need  = st.hold && st.need;

  always_comb begin
    st_n = st;
    if (drop) begin
      st_n = LIFE_IDLE;
    end else if (load) begin
      st_n.hold = 1'b1;
      st_n.need = 1'b1;
      st_n.sent = 1'b0;
    end else if (st.hold) begin
      st_n.sent = st.sent | fwd_en;
      st_n.need = st.need & !wr_gnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= LIFE_IDLE;
    else        st <= st_n;
  end

  a_r4_single_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en |=> !fwd_en);

  a_r5_fwd_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && !drop) |=> !in_ready);

  a_r6_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_need && wr_gnt && !drop) |=> !wr_need);

  a_r8_squash_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && squash) |-> (drop && !fwd_en));

  a_r9_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (in_ready && !wr_need));
endmodule

// File: rtl/fu_fwd_ctrl.sv
module fu_fwd_ctrl #(
  parameter int DW  = 16,
  parameter int NFU = 4,
  parameter int NSH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  input  logic [NFU-1:0] rd_pend,
  input  logic [NSH-1:0] shadow,
  input  logic [NFU-1:0] rd_hazard,
  input  logic           squash,
  input  logic           wr_gnt,
  output logic           fwd_en,
  output logic           wr_need,
  output logic           drop,
  output logic [DW-1:0]  res_data
);
  logic pend_any, shadow_any, hazard_any, load;

  fwdc_any #(.W(NFU)) u_pend   (.vec(rd_pend),   .any(pend_any));
  fwdc_any #(.W(NSH)) u_shadow (.vec(shadow),    .any(shadow_any));
  fwdc_any #(.W(NFU)) u_hazard (.vec(rd_hazard), .any(hazard_any));

  fwdc_life u_life (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pend_any(pend_any), .shadow_any(shadow_any), .hazard_any(hazard_any),
    .squash(squash), .wr_gnt(wr_gnt),
    .in_ready(in_ready), .load(load), .fwd_en(fwd_en),
    .wr_need(wr_need), .drop(drop)
  );

  fwdc_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .d(in_data), .q(res_data)
  );

  a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(res_data));

  a_r3_fwd_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en |-> ((rd_pend != '0) && !in_ready));

  a_r7_clear_to_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !squash) |-> ((shadow == '0) && (rd_hazard == '0)));
endmodule

// File: tb/fu_fwd_ctrl_bench.sv
module fu_fwd_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DW = 16, NFU = 4, NSH = 3;

  typedef struct {
    logic          rdy, fwd, need, drp;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, squash = 1'b0, wr_gnt = 1'b0;
  logic [DW-1:0]  in_data = '0;
  logic [NFU-1:0] rd_pend = '0, rd_hazard = '0;
  logic [NSH-1:0] shadow = '0;
  logic in_ready, fwd_en, wr_need, drop;
  logic [DW-1:0] res_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t q[$];

  // requirement-level picture of the unit's state
  logic m_hold = 1'b0, m_need = 1'b0, m_sent = 1'b0;
  logic [DW-1:0] m_data = '0;

  always #(CLK_P/2) clk = ~clk;

  fu_fwd_ctrl #(.DW(DW), .NFU(NFU), .NSH(NSH)) u_fu_fwd_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rd_pend(rd_pend), .shadow(shadow),
    .rd_hazard(rd_hazard), .squash(squash), .wr_gnt(wr_gnt),
    .fwd_en(fwd_en), .wr_need(wr_need), .drop(drop), .res_data(res_data)
  );

  task automatic cmp(input logic act, input logic expv, input string what, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic step(input logic iv, input logic [DW-1:0] d,
                      input logic [NFU-1:0] pd, input logic [NSH-1:0] sh,
                      input logic [NFU-1:0] hz, input logic sq, input logic gt,
                      input string tag);
    exp_t e;
    logic quiet;
    @(negedge clk);
    in_valid = iv; in_data = d; rd_pend = pd; shadow = sh;
    rd_hazard = hz; squash = sq; wr_gnt = gt;
    quiet  = (sh == '0) && (hz == '0);
    e.rdy  = !m_hold;
    e.fwd  = m_hold && !m_sent && (pd != '0) && !sq;   // R3
    e.drp  = m_hold && (sq || (quiet && (m_sent || !m_need))); // R7 R8 R10
    e.need = m_hold && m_need;
    e.data = m_data;
    e.tag  = tag;
    q.push_back(e);
    if (e.drp) begin
      m_hold = 1'b0; m_need = 1'b0; m_sent = 1'b0;       // R9
    end else if (!m_hold && iv) begin
      m_hold = 1'b1; m_need = 1'b1; m_sent = 1'b0; m_data = d; // R2
    end else if (m_hold) begin
      m_sent = m_sent | e.fwd;
      m_need = m_need & !gt;                            // R6
    end
  endtask

  // monitor: compare well after the drive point, well before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(in_ready, e.rdy,  "in_ready", e.tag);
        cmp(fwd_en,   e.fwd,  "fwd_en",   e.tag);
        cmp(wr_need,  e.need, "wr_need",  e.tag);
        cmp(drop,     e.drp,  "drop",     e.tag);
        n_chk++;
        if (res_data !== e.data) begin
          n_fail++;
          $display("FAIL %s res_data: actual %h expected %h", e.tag, res_data, e.data);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(0, '0, '0, '0, '0, 0, 0, "R1 reset state");
    @(negedge clk); rst_n = 1'b1;
    step(0, '0, '0, '0, '0, 0, 0, "R1 idle after reset");
    // result A: forwarded, then held by shadow and hazard, then dropped
    step(1, 16'hA5A5, '0, 3'b000, '0, 0, 0, "R2 accept A");
    step(0, '0, 4'b0000, 3'b001, '0, 0, 0, "R3 no pending read");
    step(1, 16'h5555, 4'b0010, 3'b001, '0, 0, 0, "R3 forward on pend bit1, R2 input ignored");
    step(0, '0, 4'b1000, 3'b001, '0, 0, 0, "R4 no second forward");
    step(0, '0, 4'b0000, 3'b010, '0, 0, 0, "R5 held after forward");
    step(0, '0, 4'b0000, 3'b000, 4'b0001, 0, 0, "R7 hazard blocks drop");
    step(0, '0, 4'b0000, 3'b100, 4'b0000, 0, 0, "R7 shadow bit2 blocks drop");
    step(0, '0, 4'b0000, 3'b000, 4'b0000, 0, 0, "R7 drop when clear");
    step(0, '0, '0, '0, '0, 0, 1, "R9 idle after drop, R6 stray grant");
    // result B: write granted first, then forward and drop collide
    step(1, 16'h1234, '0, '0, '0, 0, 0, "R2 accept B");
    step(0, '0, 4'b0000, 3'b010, '0, 0, 1, "R6 grant while shadowed");
    step(0, '0, 4'b0000, 3'b010, '0, 0, 0, "R6 need cleared");
    step(0, '0, 4'b1000, 3'b000, 4'b0000, 0, 0, "R7 forward and drop together");
    step(0, '0, 4'b1000, '0, '0, 0, 0, "R9 idle after collision");
    // result C: never forwarded nor written, then squashed with pending reads
    step(1, 16'hBEEF, '0, '0, '0, 0, 0, "R2 accept C");
    step(0, '0, 4'b0000, 3'b000, 4'b0000, 0, 0, "R10 not dropped unsent");
    step(0, '0, 4'b0100, 3'b001, 4'b0010, 1, 0, "R8 squash beats forward");
    step(0, '0, '0, '0, '0, 0, 0, "R9 idle after squash");
    // result D: squash with grant in the same cycle
    step(1, 16'h0F0F, '0, '0, '0, 0, 0, "R2 accept D");
    step(0, '0, 4'b0001, 3'b000, 4'b0000, 1, 1, "R8 squash with grant");
    step(0, '0, '0, '0, '0, 0, 0, "R9 idle after squash D");
    @(negedge clk);
    @(negedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule